// File: doc/BRIEF.md
# Video Port Output Stream Formatter

This block turns a stream of co-sited luma/chroma pixel samples into a byte-serial 4:2:2 video stream for a parallel output port. Samples arrive with a valid flag, together with a horizontal (line) window, a vertical (frame) window and a field flag. The block emits one byte per clock, with no handshake and no stall. At every line start it inserts a four-byte timing preamble: FF, 00, 00 and then a start-of-active-video code. After the preamble come the accepted samples, in the component order Cb, Y, Cr, Y. Every cycle that carries no sample is filled with 00h and has its qualifier low.

Beside the data bus the block drives active-high horizontal and vertical gates. It can add a one-clock reference pulse on the rising edge of each gate, and each pulse has its own enable. It also drives a data qualifier. A configuration input selects whether the qualifier pin is a plain level or a gated clock, which is the port clock ANDed with the qualifier level.

Data and gates have a latency of four clock edges. The same four edges are the slot for the preamble, so it fits without any storage beyond a 4-deep delay line. For this to work, the horizontal gate must stay low for at least four cycles between lines.

The formatter is a state machine with six states:
- `S_IDLE`: the gate is low and fill bytes are output.
- `S_PRE_FF`, `S_PRE_Z1`, `S_PRE_Z2`, `S_PRE_SAV`: the preamble bytes, in that order.
- `S_ACTIVE`: delayed samples are output.

Its transitions are:
- `line_start`: from any state to `S_PRE_FF` when the input gate rises.
- `pre_step`: through the four preamble states, one per clock.
- `pre_done`: from `S_PRE_SAV` to `S_ACTIVE`.
- `line_end`: from `S_ACTIVE` to `S_IDLE` when the delayed gate is low.
- `late_gate`: from `S_IDLE` to `S_ACTIVE` if the delayed gate is high without a preamble.

Top module: `vof_stream_fmt`

## Requirements
- R1: While reset is asserted, every output is low and the data bus carries 00h.
- R2: A cycle that is neither a preamble cycle nor carries an accepted sample drives 00h with the qualifier low.
- R3: The qualifier level is high exactly on the cycles that carry an accepted sample, four clock edges after the edge that took the sample in.
- R4: When the edge samples the horizontal gate high after it was low, the output is FF on that edge. It is then 00 and 00 on the next two edges, and the start code on the third.
- R5: The start code is bit7=1, bit6=F (field input), bit5=V (1 when the vertical gate input is low at line start), bit4=H=0, bit3=V^H, bit2=F^H, bit1=F^V, bit0=F^V^H.
- R6: Accepted samples in a line are counted from 0. Index mod 4 = 0 takes chroma (Cb), 2 takes chroma (Cr), and odd indices take luma. The count restarts at each line and advances only on accepted samples.
- R7: An accepted byte of 00h is output as 01h, and one of FFh as FEh.
- R8: The output horizontal and vertical gates equal the input gates delayed by four clock edges.
- R9: With its enable set, the horizontal reference output is a one-cycle pulse on the first high cycle of the output horizontal gate. With the enable clear, it stays low.
- R10: With its enable set, the vertical reference output is a one-cycle pulse on the first high cycle of the output vertical gate. With the enable clear, it stays low.
- R11: With the clock-mode input low, the qualifier pin equals the qualifier level. With it high, the pin equals the clock ANDed with that level.
- R12: A valid flag presented while the horizontal gate input is low is ignored. It produces no qualifier and a 00h byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_luma | input | 8 | Luma component of the current pixel |
| in_chroma | input | 8 | Chroma component of the current pixel |
| in_valid | input | 1 | Current pixel is a real sample |
| in_hgate | input | 1 | Line active window |
| in_vgate | input | 1 | Frame active window |
| in_field | input | 1 | Field flag for the start code |
| cfg_href_en | input | 1 | Enable horizontal reference pulse |
| cfg_vref_en | input | 1 | Enable vertical reference pulse |
| cfg_dq_clk | input | 1 | Qualifier pin outputs a gated clock |
| out_data | output | 8 | Serial video byte |
| out_hgate | output | 1 | Horizontal gate, active high |
| out_vgate | output | 1 | Vertical gate, active high |
| out_href | output | 1 | Horizontal reference pulse |
| out_vref | output | 1 | Vertical reference pulse |
| out_dq | output | 1 | Data qualifier (level or gated clock) |

## Verification
The bench sweeps every combination of field and vertical-blank flag against four valid-flag patterns. One of these patterns holds the valid flag high through the blanking interval. A formatter with a wrong start-code bit, or one that accepts samples outside the gate, shows up as a bad byte or a stray qualifier. Lines with sparse valid patterns catch a component phase that advances on idle cycles: the bytes would come out with chroma and luma swapped. The clip values are placed where the Cb, first-Y and Cr slots land, so a missing clip shows up as a data byte that aliases a preamble code. Every cycle is sampled with the clock both high and low in the gated-clock mode, which catches a pin that ignores the mode or the clock.

// File: rtl/vof_pkg.sv
package vof_pkg;

    localparam int BYTE_W   = 8;
    localparam int LEAD_LEN = 4;
    localparam int PH_W     = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t b;
        logic  vld;
        logic  hg;
        logic  vg;
    } slot_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_FF,
        S_PRE_Z1,
        S_PRE_Z2,
        S_PRE_SAV,
        S_ACTIVE
    } fsm_t;

    localparam byte_t CODE_ZERO = '0;
    localparam byte_t CODE_ONES = '1;

    // start code: fixed 1, F, V, H, then protection bits
    function automatic byte_t sav_code(input logic f, input logic v);
        logic h;
        h = 1'b0;
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // keep payload away from the reserved timing codes
    function automatic byte_t clip_code(input byte_t x);
        if (x == CODE_ZERO)      return CODE_ZERO + byte_t'(1);
        else if (x == CODE_ONES) return CODE_ONES - byte_t'(1);
        else                     return x;
    endfunction

endpackage

// File: rtl/vof_sample_sel.sv
module vof_sample_sel
    import vof_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t in_luma,
    input  byte_t in_chroma,
    input  logic  in_valid,
    input  logic  in_hgate,
    input  logic  in_vgate,
    output slot_t slot_q
);

    logic [PH_W-1:0] phase_q;
    logic            accept;
    byte_t           pick;

    assign accept = in_valid & in_hgate;

    // even phase takes chroma (Cb then Cr), odd phase takes luma
    always_comb begin
        if (phase_q[0]) pick = in_luma;
        else            pick = in_chroma;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!in_hgate) begin
            phase_q <= '0;
        end else if (accept) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q.b   <= accept ? clip_code(pick) : CODE_ZERO;
            slot_q.vld <= accept;
            slot_q.hg  <= in_hgate;
            slot_q.vg  <= in_vgate;
        end
    end

    assert_phase_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hgate |=> phase_q == '0);

    assert_gate_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hgate |=> !slot_q.vld);

endmodule

// File: rtl/vof_delay.sv
module vof_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stage_q [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= '0;
                    else if (i == 0) stage_q[i] <= d;
                    else stage_q[i] <= stage_q[(i > 0) ? i - 1 : 0];
                end
            end
            assign q = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/vof_frame_fsm.sv
module vof_frame_fsm
    import vof_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_hgate,
    input  logic  in_vgate,
    input  logic  in_field,
    input  slot_t tail,
    input  logic  cfg_href_en,
    input  logic  cfg_vref_en,
    output byte_t data_q,
    output logic  dq_q,
    output logic  hg_q,
    output logic  vg_q,
    output logic  href_q,
    output logic  vref_q
);

    fsm_t  state_q, state_d;
    logic  h_prev_q;
    logic  rise;
    byte_t sav_q;
    byte_t byte_d;
    logic  dq_d;

    assign rise = in_hgate & ~h_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_prev_q <= 1'b0;
            sav_q    <= CODE_ZERO;
        end else begin
            h_prev_q <= in_hgate;
            if (rise) sav_q <= sav_code(in_field, ~in_vgate);
        end
    end

    // next state: line_start wins over everything
    always_comb begin
        state_d = state_q;
        if (rise) begin
            state_d = S_PRE_FF;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = tail.hg ? S_ACTIVE : S_IDLE;
                S_PRE_FF:  state_d = S_PRE_Z1;
                S_PRE_Z1:  state_d = S_PRE_Z2;
                S_PRE_Z2:  state_d = S_PRE_SAV;
                S_PRE_SAV: state_d = S_ACTIVE;
                S_ACTIVE:  state_d = tail.hg ? S_ACTIVE : S_IDLE;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // byte selection for the state being entered
    always_comb begin
        byte_d = CODE_ZERO;
        dq_d   = 1'b0;
        unique case (state_d)
            S_PRE_FF:  byte_d = CODE_ONES;
            S_PRE_Z1:  byte_d = CODE_ZERO;
            S_PRE_Z2:  byte_d = CODE_ZERO;
            S_PRE_SAV: byte_d = sav_q;
            S_IDLE, S_ACTIVE: begin
                byte_d = tail.vld ? tail.b : CODE_ZERO;
                dq_d   = tail.vld;
            end
            default: begin
                byte_d = CODE_ZERO;
                dq_d   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= CODE_ZERO;
            dq_q   <= 1'b0;
            hg_q   <= 1'b0;
            vg_q   <= 1'b0;
            href_q <= 1'b0;
            vref_q <= 1'b0;
        end else begin
            data_q <= byte_d;
            dq_q   <= dq_d;
            hg_q   <= tail.hg;
            vg_q   <= tail.vg;
            href_q <= cfg_href_en & tail.hg & ~hg_q;
            vref_q <= cfg_vref_en & tail.vg & ~vg_q;
        end
    end

    assert_fill_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dq_q && (state_q == S_IDLE || state_q == S_ACTIVE)) |-> data_q == CODE_ZERO);

    assert_payload_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dq_q |-> (data_q != CODE_ZERO && data_q != CODE_ONES));

    assert_pre_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRE_FF) |=> (data_q == CODE_ZERO || data_q == CODE_ONES));

    assert_sav_format_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRE_SAV) |-> (data_q[7] && !data_q[4] &&
                                    data_q[3] == data_q[5] && data_q[2] == data_q[6]));

    assert_href_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        href_q |-> (hg_q && !$past(hg_q)));

    assert_href_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        href_q |=> !href_q);

    assert_vref_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vref_q |-> (vg_q && !$past(vg_q)));

    assert_vref_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vref_q |=> !vref_q);

endmodule

// File: rtl/vof_stream_fmt.sv
module vof_stream_fmt
    import vof_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_luma,
    input  logic [7:0] in_chroma,
    input  logic       in_valid,
    input  logic       in_hgate,
    input  logic       in_vgate,
    input  logic       in_field,
    input  logic       cfg_href_en,
    input  logic       cfg_vref_en,
    input  logic       cfg_dq_clk,
    output logic [7:0] out_data,
    output logic       out_hgate,
    output logic       out_vgate,
    output logic       out_href,
    output logic       out_vref,
    output logic       out_dq
);

    localparam int SLOT_W  = $bits(slot_t);
    localparam int DLY_LEN = LEAD_LEN - 1;

    slot_t head;
    slot_t tail;
    logic  dq_lvl;

    vof_sample_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_luma   (in_luma),
        .in_chroma (in_chroma),
        .in_valid  (in_valid),
        .in_hgate  (in_hgate),
        .in_vgate  (in_vgate),
        .slot_q    (head)
    );

    vof_delay #(
        .W     (SLOT_W),
        .DEPTH (DLY_LEN)
    ) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (head),
        .q     (tail)
    );

    vof_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_hgate    (in_hgate),
        .in_vgate    (in_vgate),
        .in_field    (in_field),
        .tail        (tail),
        .cfg_href_en (cfg_href_en),
        .cfg_vref_en (cfg_vref_en),
        .data_q      (out_data),
        .dq_q        (dq_lvl),
        .hg_q        (out_hgate),
        .vg_q        (out_vgate),
        .href_q      (out_href),
        .vref_q      (out_vref)
    );

    // R11: qualifier pin as level or as clock gated by the level
    assign out_dq = cfg_dq_clk ? (clk & dq_lvl) : dq_lvl;

endmodule

// File: tb/test_vof_stream_fmt.sv
`timescale 1ns/1ps
module test_vof_stream_fmt;

    localparam int N = 1024;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_luma, in_chroma;
    logic       in_valid, in_hgate, in_vgate, in_field;
    logic       cfg_href_en, cfg_vref_en, cfg_dq_clk;
    logic [7:0] out_data;
    logic       out_hgate, out_vgate, out_href, out_vref, out_dq;

    always #2.5 clk = ~clk;

    vof_stream_fmt i_vof_stream_fmt (
        .clk(clk), .rst_n(rst_n), .in_luma(in_luma), .in_chroma(in_chroma),
        .in_valid(in_valid), .in_hgate(in_hgate), .in_vgate(in_vgate),
        .in_field(in_field), .cfg_href_en(cfg_href_en), .cfg_vref_en(cfg_vref_en),
        .cfg_dq_clk(cfg_dq_clk), .out_data(out_data), .out_hgate(out_hgate),
        .out_vgate(out_vgate), .out_href(out_href), .out_vref(out_vref),
        .out_dq(out_dq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    int    ek    = 0;

    logic [7:0] e_data [N];
    logic       e_dq   [N];
    logic       e_hg   [N];
    logic       e_vg   [N];
    logic       e_href [N];
    logic       e_vref [N];
    string      e_tag  [N];

    logic       m_hg_prev = 0;
    logic       m_vg_prev = 0;
    int         m_idx     = 0;

    function automatic logic [7:0] m_clip(input logic [7:0] x);
        if (x == 8'h00) return 8'h01;
        if (x == 8'hFF) return 8'hFE;
        return x;
    endfunction

    function automatic logic [7:0] m_sav(input logic f, input logic v);
        return 8'h80 | (8'(f) << 6) | (8'(v) << 5) | (8'(v) << 3) |
               (8'(f) << 2) | (8'(f ^ v) << 1) | 8'(f ^ v);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s edge %0d: got %0h expected %0h", req, what, ek, act, exp);
        end
    endtask

    // expected outputs from the requirements, for the edge that samples these inputs
    task automatic model(input logic hg, input logic vg, input logic fld,
                         input logic vld, input logic [7:0] l, input logic [7:0] c);
        logic rise;
        rise = hg & ~m_hg_prev;
        if (rise) begin
            e_data[ek]   = 8'hFF; e_tag[ek]   = "R4";
            e_data[ek+1] = 8'h00; e_tag[ek+1] = "R4";
            e_data[ek+2] = 8'h00; e_tag[ek+2] = "R4";
            e_data[ek+3] = m_sav(fld, ~vg); e_tag[ek+3] = "R5";
        end
        if (!hg) m_idx = 0;
        e_hg[ek+4]   = hg;
        e_vg[ek+4]   = vg;
        e_href[ek+4] = cfg_href_en & hg & ~m_hg_prev;
        e_vref[ek+4] = cfg_vref_en & vg & ~m_vg_prev;
        if (vld && !hg) e_tag[ek+4] = "R12";
        if (vld && hg) begin
            logic [7:0] raw;
            raw = (m_idx % 2 == 0) ? c : l;
            e_dq[ek+4]   = 1'b1;
            e_data[ek+4] = m_clip(raw);
            e_tag[ek+4]  = (raw == 8'h00 || raw == 8'hFF) ? "R7" : "R6";
            m_idx++;
        end
        m_hg_prev = hg;
        m_vg_prev = vg;
    endtask

    task automatic step(input logic hg, input logic vg, input logic fld,
                        input logic vld, input logic [7:0] l, input logic [7:0] c);
        in_hgate = hg; in_vgate = vg; in_field = fld; in_valid = vld;
        in_luma = l; in_chroma = c;
        model(hg, vg, fld, vld, l, c);
        @(posedge clk);
        #1.25;
        chk(out_data == e_data[ek], e_tag[ek], "data", out_data, e_data[ek]);
        chk(out_hgate == e_hg[ek], "R8", "hgate", out_hgate, e_hg[ek]);
        chk(out_vgate == e_vg[ek], "R8", "vgate", out_vgate, e_vg[ek]);
        chk(out_href == e_href[ek], "R9", "href", out_href, e_href[ek]);
        chk(out_vref == e_vref[ek], "R10", "vref", out_vref, e_vref[ek]);
        chk(out_dq == e_dq[ek], (e_tag[ek] == "R12") ? "R12" : "R3", "dq_high_phase",
            out_dq, e_dq[ek]);
        #2.5;
        // clock low: gated mode forces the pin low (R11)
        chk(out_dq == (cfg_dq_clk ? 1'b0 : e_dq[ek]), "R11", "dq_low_phase",
            out_dq, cfg_dq_clk ? 1'b0 : e_dq[ek]);
        ek++;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            e_data[i] = 8'h00; e_dq[i] = 0; e_hg[i] = 0; e_vg[i] = 0;
            e_href[i] = 0; e_vref[i] = 0; e_tag[i] = "R2";
        end
        rst_n = 0;
        in_hgate = 1; in_vgate = 1; in_field = 1; in_valid = 1;
        in_luma = 8'h5A; in_chroma = 8'hA5;
        cfg_href_en = 1; cfg_vref_en = 1; cfg_dq_clk = 0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1.25;
            chk(out_data == 8'h00, "R1", "reset data", out_data, 0);
            chk({out_hgate, out_vgate, out_href, out_vref, out_dq} == 5'b0,
                "R1", "reset flags", {out_hgate, out_vgate, out_href, out_vref, out_dq}, 0);
            #2.5;
        end
        in_hgate = 0; in_vgate = 0; in_valid = 0;
        rst_n = 1;

        for (int li = 0; li < 32; li++) begin
            logic f, vg;
            int   p;
            f  = li[0];
            vg = ~li[1];
            p  = (li >> 2) & 3;
            cfg_dq_clk  = li[4];
            cfg_href_en = li[0] ^ li[4];
            cfg_vref_en = li[2] | li[4];
            for (int j = 0; j < 8; j++)
                step(0, vg, f, (p == 3), 8'(li * 3 + j), 8'(li * 5 + j));
            for (int j = 0; j < 10; j++) begin
                logic       v;
                logic [7:0] l, c;
                case (p)
                    0:       v = 1;
                    1:       v = (j % 2 == 0);
                    2:       v = (j % 3 != 1);
                    default: v = (j != 4);
                endcase
                l = 8'(li * 29 + j * 11 + 5);
                c = 8'(li * 17 + j * 7 + 64);
                if (j == 0) c = 8'h00;
                if (j == 1) l = 8'hFF;
                if (j == 2) c = 8'hFF;
                if (j == 3) l = 8'h00;
                step(1, vg, f, v, l, c);
            end
        end
        for (int j = 0; j < 12; j++) step(0, 0, 0, 0, 8'h00, 8'h00);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule